// File: doc/BRIEF.md
# Local Interrupt Table Dispatcher

This block sits beside a processor core and owns three local interrupt source entries: one for the timer and one each for two local interrupt lines. Each entry says whether the source is masked, how its events are delivered, which vector a fixed-mode event targets, and (for the two lines) whether that vector is level-triggered. When a source fires, the block reads the matching entry. It then either marks the vector pending in a 256-bit pending register or raises one of the processor's dedicated interrupt outputs: system management, non-maskable, or external.

Line 0 also has a release event. It withdraws a level-triggered fixed request, or drops the external interrupt output. A delivery counter counts only the events that newly set a pending bit. A software pulse clears it. Priority arbitration and in-service tracking belong to a downstream block that reads the pending and trigger vectors.

Top module: `lvt_dispatch`

## Requirements
- R1: After reset, `pend`, `trig`, `dlv_cnt`, `ext_req`, `smi_pulse` and `nmi_pulse` are all zero. The timer and line 1 entries reset masked. With `CTRL_ID` = 0, the line 0 entry resets to 0x00700 (unmasked, external mode), so a line 0 event raises `ext_req`.
- R2: An entry whose bit 16 (mask) is set produces no change at any output when its source fires.
- R3: Delivery mode is entry bits 10:8, and fixed mode is 0. A fixed-mode event sets `pend[v]` on the clock edge that samples it, where v is entry bits 7:0. Pending bits are never cleared except by R7.
- R4: A fixed-mode event sets `trig[v]` only when the source is line 0 or line 1 and entry bit 15 is set. A timer event never touches `trig`, whatever its bit 15 holds, and an edge event leaves `trig` unchanged.
- R5: Mode 2 gives a one-cycle pulse on `smi_pulse`, and mode 4 gives one on `nmi_pulse`. Neither touches `pend`, `trig` or `dlv_cnt`. With no event in a cycle, both pulses are low in the next cycle.
- R6: Mode 7 sets `ext_req`, which stays high until a line 0 release removes it.
- R7: On `line0_drop`, the line 0 entry decides what happens. In fixed mode with bit 15 set, `pend[v]` is cleared and `ext_req` falls. In external mode, `ext_req` falls. In fixed mode with edge trigger, nothing changes. The mask bit does not gate a release.
- R8: `dlv_cnt` rises by one for each fixed event whose target pending bit was clear just before that event. A `cnt_clear` pulse makes it zero, and it wins over increments in the same cycle.
- R9: Events in the same cycle are applied in the order timer, line 0, line 1, and a line 0 release is applied after them. Two events to one clear vector in one cycle therefore count once.
- R10: Modes 1, 3, 5 and 6 produce no change at any output.
- R11: With `cfg_we` high, `cfg_sel` picks the entry (0 timer, 1 line 0, 2 line 1). The write affects only events in later cycles. `cfg_sel` = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_sel | input | 2 | Entry select: 0 timer, 1 line 0, 2 line 1 |
| cfg_wdata | input | 17 | Entry value: [16] mask, [15] level, [10:8] mode, [7:0] vector |
| tmr_fire | input | 1 | Timer event, one cycle |
| line0_fire | input | 1 | Line 0 assertion event |
| line1_fire | input | 1 | Line 1 assertion event |
| line0_drop | input | 1 | Line 0 release event |
| cnt_clear | input | 1 | Clears the delivery counter |
| pend | output | NVEC | Pending request bits |
| trig | output | NVEC | Level-trigger bits per vector |
| ext_req | output | 1 | External interrupt request level |
| smi_pulse | output | 1 | System management interrupt pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| dlv_cnt | output | CNT_W | Count of newly pending deliveries |

## Verification
Each output is one register, so a wrong entry field, a wrong mode decode or a wrong order of sources shows up in the cycle right after the event. It appears as an unexpected or missing pending bit, trigger bit or interrupt line. A counter that counts re-deliveries drifts above the expected value on the first repeated vector. A wrong release decode shows up as a pending bit or `ext_req` that survives `line0_drop`, or as one that falls when it should stay. The stimulus walks one stateful sequence through every mode and trigger combination. Directed cases then cover same-cycle collisions, writes that coincide with events, and an out-of-range select.

// File: rtl/lvt_dispatch.sv
`timescale 1ns/1ps
module lvt_dispatch #(
  parameter int CTRL_ID = 0,
  parameter int NVEC    = 256,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [16:0]      cfg_wdata,
  input  logic             tmr_fire,
  input  logic             line0_fire,
  input  logic             line1_fire,
  input  logic             line0_drop,
  input  logic             cnt_clear,
  output logic [NVEC-1:0]  pend,
  output logic [NVEC-1:0]  trig,
  output logic             ext_req,
  output logic             smi_pulse,
  output logic             nmi_pulse,
  output logic [CNT_W-1:0] dlv_cnt
);
  localparam int VW     = $clog2(NVEC);
  localparam int NSRC   = 3;
  localparam int B_MASK = 12;
  localparam int B_LVL  = 11;
  localparam logic [2:0] MD_FIXED = 3'd0;
  localparam logic [2:0] MD_SMI   = 3'd2;
  localparam logic [2:0] MD_NMI   = 3'd4;
  localparam logic [2:0] MD_EXT   = 3'd7;
  localparam logic [12:0] ENT_OFF  = 13'h1000;
  localparam logic [12:0] ENT_L0RS = (CTRL_ID == 0) ? 13'h0700 : ENT_OFF;

  logic [12:0] ent_q [NSRC];
  logic [NSRC-1:0] fire_v;
  logic [NVEC-1:0] pend_n, trig_n;
  logic [CNT_W-1:0] cnt_n;
  logic ext_n, smi_n, nmi_n;
  logic unused_wbits;

  assign fire_v = {line1_fire, line0_fire, tmr_fire};
  assign unused_wbits = &{1'b0, cfg_wdata[14:11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q[0] <= ENT_OFF;
      ent_q[1] <= ENT_L0RS;
      ent_q[2] <= ENT_OFF;
    end else if (cfg_we && cfg_sel != 2'd3) begin
      ent_q[cfg_sel] <= {cfg_wdata[16], cfg_wdata[15], cfg_wdata[10:0]};
    end
  end

  always_comb begin
    pend_n = pend;
    trig_n = trig;
    cnt_n  = dlv_cnt;
    ext_n  = ext_req;
    smi_n  = 1'b0;
    nmi_n  = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (fire_v[k] && !ent_q[k][B_MASK]) begin
        case (ent_q[k][10:8])
          MD_FIXED: begin
            if (!pend_n[ent_q[k][VW-1:0]]) cnt_n = cnt_n + 1'b1;
            pend_n[ent_q[k][VW-1:0]] = 1'b1;
            if (k != 0 && ent_q[k][B_LVL]) trig_n[ent_q[k][VW-1:0]] = 1'b1;
          end
          MD_SMI: smi_n = 1'b1;
          MD_NMI: nmi_n = 1'b1;
          MD_EXT: ext_n = 1'b1;
          default: ;
        endcase
      end
    end
    if (line0_drop) begin
      if (ent_q[1][10:8] == MD_FIXED && ent_q[1][B_LVL]) begin
        pend_n[ent_q[1][VW-1:0]] = 1'b0;
        ext_n = 1'b0;
      end else if (ent_q[1][10:8] == MD_EXT) begin
        ext_n = 1'b0;
      end
    end
    if (cnt_clear) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      trig      <= '0;
      dlv_cnt   <= '0;
      ext_req   <= 1'b0;
      smi_pulse <= 1'b0;
      nmi_pulse <= 1'b0;
    end else begin
      pend      <= pend_n;
      trig      <= trig_n;
      dlv_cnt   <= cnt_n;
      ext_req   <= ext_n;
      smi_pulse <= smi_n;
      nmi_pulse <= nmi_n;
    end
  end

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_fire && ent_q[0][B_MASK] && !line0_fire && !line1_fire && !line0_drop)
      |=> ($stable(pend) && $stable(trig) && !smi_pulse && !nmi_pulse));

  // R3
  fixed_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_fire && !ent_q[0][B_MASK] && ent_q[0][10:8] == MD_FIXED && !line0_drop)
      |=> pend[$past(ent_q[0][VW-1:0])]);

  // R3
  pend_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line0_drop |=> ((pend & $past(pend)) == $past(pend)));

  // R5
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_v == '0) |=> (!smi_pulse && !nmi_pulse));

  // R7
  ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line0_drop && ent_q[1][10:8] == MD_EXT) |=> !ext_req);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (dlv_cnt == '0));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_v == '0 && !cnt_clear) |=> $stable(dlv_cnt));
endmodule

// File: tb/lvt_dispatch_test.sv
`timescale 1ns/1ps
module lvt_dispatch_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [16:0] cfg_wdata = 0;
  logic tmr_fire = 0, line0_fire = 0, line1_fire = 0, line0_drop = 0, cnt_clear = 0;
  logic [255:0] pend, trig;
  logic ext_req, smi_pulse, nmi_pulse;
  logic [7:0] dlv_cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lvt_dispatch uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tmr_fire(tmr_fire), .line0_fire(line0_fire),
    .line1_fire(line1_fire), .line0_drop(line0_drop), .cnt_clear(cnt_clear),
    .pend(pend), .trig(trig), .ext_req(ext_req), .smi_pulse(smi_pulse),
    .nmi_pulse(nmi_pulse), .dlv_cnt(dlv_cnt));

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [16:0] ent;
    logic [2:0]  fire;   // {line1, line0, timer}
    logic        drop;
    logic [7:0]  vec;
    logic [4:0]  exp;    // {pend[vec], trig[vec], ext, smi, nmi}
    logic [7:0]  cnt;
  } step_t;

  localparam logic [44:0] TBL [16] = '{
    {1'b0,2'd0,17'h00000,3'b010,1'b0,8'h00,5'b00100,8'd0},
    {1'b1,2'd0,17'h00030,3'b001,1'b0,8'h30,5'b10100,8'd1},
    {1'b1,2'd0,17'h08031,3'b001,1'b0,8'h31,5'b10100,8'd2},
    {1'b1,2'd2,17'h08040,3'b100,1'b0,8'h40,5'b11100,8'd3},
    {1'b0,2'd2,17'h00000,3'b100,1'b0,8'h40,5'b11100,8'd3},
    {1'b1,2'd1,17'h08050,3'b010,1'b0,8'h50,5'b11100,8'd4},
    {1'b0,2'd0,17'h00000,3'b000,1'b1,8'h50,5'b01000,8'd4},
    {1'b1,2'd1,17'h00060,3'b010,1'b0,8'h60,5'b10000,8'd5},
    {1'b0,2'd0,17'h00000,3'b000,1'b1,8'h60,5'b10000,8'd5},
    {1'b1,2'd2,17'h00700,3'b100,1'b0,8'h60,5'b10100,8'd5},
    {1'b0,2'd0,17'h00000,3'b000,1'b1,8'h60,5'b10100,8'd5},
    {1'b1,2'd0,17'h00200,3'b001,1'b0,8'h00,5'b00110,8'd5},
    {1'b1,2'd0,17'h00400,3'b001,1'b0,8'h00,5'b00101,8'd5},
    {1'b1,2'd0,17'h10070,3'b001,1'b0,8'h70,5'b00100,8'd5},
    {1'b1,2'd0,17'h00170,3'b001,1'b0,8'h70,5'b00100,8'd5},
    {1'b1,2'd1,17'h00700,3'b000,1'b1,8'h50,5'b01000,8'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [16:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic ev(input logic [2:0] f, input logic dr, input logic clr);
    @(negedge clk);
    {line1_fire, line0_fire, tmr_fire} = f; line0_drop = dr; cnt_clear = clr;
    @(negedge clk);
    {line1_fire, line0_fire, tmr_fire} = 3'b000; line0_drop = 0; cnt_clear = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pend", {31'd0, |pend}, 0);
    chk("R1 trig", {31'd0, |trig}, 0);
    chk("R1 outs", {28'd0, ext_req, smi_pulse, nmi_pulse, 1'b0}, 0);
    chk("R1 cnt", {24'd0, dlv_cnt}, 0);

    // table walk: R1 R3 R4 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < 16; i++) begin
      step_t s;
      s = step_t'(TBL[i]);
      if (s.we) begin
        @(negedge clk); cfg_we = 1; cfg_sel = s.sel; cfg_wdata = s.ent;
        @(negedge clk); cfg_we = 0;
        {line1_fire, line0_fire, tmr_fire} = s.fire; line0_drop = s.drop;
      end else begin
        @(negedge clk);
        {line1_fire, line0_fire, tmr_fire} = s.fire; line0_drop = s.drop;
      end
      @(negedge clk);
      {line1_fire, line0_fire, tmr_fire} = 3'b000; line0_drop = 0;
      chk($sformatf("R3/R7 step %0d pend", i), {31'd0, pend[s.vec]}, {31'd0, s.exp[4]});
      chk($sformatf("R4 step %0d trig", i), {31'd0, trig[s.vec]}, {31'd0, s.exp[3]});
      chk($sformatf("R6/R7 step %0d ext", i), {31'd0, ext_req}, {31'd0, s.exp[2]});
      chk($sformatf("R5/R10 step %0d smi", i), {31'd0, smi_pulse}, {31'd0, s.exp[1]});
      chk($sformatf("R5/R10 step %0d nmi", i), {31'd0, nmi_pulse}, {31'd0, s.exp[0]});
      chk($sformatf("R8 step %0d cnt", i), {24'd0, dlv_cnt}, {24'd0, s.cnt});
    end

    // R2 masked entries after reset
    do_reset();
    ev(3'b101, 0, 0);
    chk("R2 masked pend", {31'd0, |pend}, 0);
    chk("R2 masked cnt", {24'd0, dlv_cnt}, 0);

    // R11 select 3 writes nothing
    wr(2'd3, 17'h00090);
    ev(3'b111, 0, 0);
    chk("R11 sel3 pend", {31'd0, |pend}, 0);
    chk("R1 line0 ext", {31'd0, ext_req}, 1);

    // R9 same-cycle collision
    wr(2'd0, 17'h00090);
    wr(2'd2, 17'h08090);
    ev(3'b101, 0, 0);
    chk("R9 pend", {31'd0, pend[8'h90]}, 1);
    chk("R9 trig", {31'd0, trig[8'h90]}, 1);
    chk("R9 cnt once", {24'd0, dlv_cnt}, 1);

    // R8 clear, and clear winning over a same-cycle increment
    ev(3'b000, 0, 1);
    chk("R8 clear", {24'd0, dlv_cnt}, 0);
    wr(2'd0, 17'h000A0);
    ev(3'b001, 0, 1);
    chk("R8 clear wins cnt", {24'd0, dlv_cnt}, 0);
    chk("R8 clear wins pend", {31'd0, pend[8'hA0]}, 1);

    // R11 write coincident with event uses old entry
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 17'h000B0; tmr_fire = 1;
    @(negedge clk);
    cfg_we = 0; tmr_fire = 0;
    chk("R11 old entry", {31'd0, pend[8'hB0]}, 0);
    chk("R11 old entry cnt", {24'd0, dlv_cnt}, 0);
    ev(3'b001, 0, 0);
    chk("R11 new entry", {31'd0, pend[8'hB0]}, 1);
    chk("R11 new entry cnt", {24'd0, dlv_cnt}, 1);

    done = 1;
    finish_run();
  end
endmodule